// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's-complement words over several clock cycles. It uses one adder/subtractor and a single double-width product register. At the start of an operation the multiplier operand goes into the low half of that register, the high half is cleared, and the multiplicand is captured in its own register. Then, once per multiplier bit, the block looks at the lowest bit of the product register together with the bit that was shifted out on the previous step. That pair decides whether the multiplicand is subtracted from the high half, added to it, or left alone. The whole register then shifts right arithmetically by one place.

A controller requests an operation by pulsing `start` while the block is idle. It then waits for the one-cycle `done` pulse and reads the upper and lower result words. The control is a three-state machine:

- **ST_IDLE** waits. Its transition *accept* (start seen) loads the operands and moves to ST_RUN.
- **ST_RUN** performs one Booth step per cycle. Its transition *last_step* (step counter at WIDTH-1) moves to ST_DONE.
- **ST_DONE** raises `done` for one cycle. Its transition *retire* returns unconditionally to ST_IDLE.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset, `busy`, `done`, `prod_hi` and `prod_lo` are all 0.
- R2: A `start` sampled high in ST_IDLE is accepted. From the next cycle `busy` is 1, and it stays 1 through ST_RUN and ST_DONE.
- R3: `done` is 1 for exactly one cycle. That cycle follows the 32nd rising edge after the edge that accepted `start`; that is, after WIDTH Booth steps, one per cycle.
- R4: For non-negative operands, {`prod_hi`,`prod_lo`} equals the 64-bit product of `op_a` (multiplicand) and `op_b` (multiplier).
- R5: Operands of mixed or negative sign give the correct signed two's-complement 64-bit product; for example, -2 times 7 gives 0xFFFF_FFFF_FFFF_FFF2.
- R6: Extreme operands give exact results: the most negative value squared gives 2^62, the most negative value times -1 gives +2^31, and zero times anything gives 0.
- R7: A `start` while `busy` is 1 is ignored. The running operation's timing and result are unchanged.
- R8: The product stays stable from `done` until the next accepted `start`.
- R9: In each step, the pair (low product bit, previous bit) selects the arithmetic: 1,0 subtracts the multiplicand from the high half, 0,1 adds it, and 0,0 or 1,1 does nothing. The previous bit is 0 before the first step. Alternating and all-ones multiplier patterns must give correct products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a multiply; honoured only when idle |
| op_a | input | 32 | Signed multiplicand |
| op_b | input | 32 | Signed multiplier |
| busy | output | 1 | Operation in progress (ST_RUN or ST_DONE) |
| done | output | 1 | One-cycle pulse when the product is final |
| prod_hi | output | 32 | Upper word of the signed product |
| prod_lo | output | 32 | Lower word of the signed product |

## Verification
Among the corner cases, the most negative multiplicand is the most revealing. A design that keeps the high-half sum at only 32 bits overflows when it subtracts that value, and the wrong bit it shifts in returns a wrong sign for min×min and for min×-1. An all-ones or alternating multiplier exercises every recoding pair; swapping add and subtract, or leaving the previous bit uncleared before the first step, shows up as a wrong product. Each test counts the cycles from the accepting edge to `done` to catch an off-by-one in the step counter. The bench also pulses `start` during both the run and the done cycle, so a design that restarts then corrupts the first result or shifts the `done` pulse.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_t;

    // Recode the pair (current low bit, previously shifted-out bit)
    function automatic booth_op_t booth_decode(input logic cur, input logic prev);
        booth_op_t op;
        unique case ({cur, prev})
            2'b10:   op = OP_SUB;
            2'b01:   op = OP_ADD;
            default: op = OP_NONE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    import booth_pkg::*;

    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    state_t state_q, state_d;
    logic [CW-1:0] cnt_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)         state_d = ST_RUN;   // accept
            ST_RUN:  if (cnt_q == LAST) state_d = ST_DONE;  // last_step
            ST_DONE:                    state_d = ST_IDLE;  // retire
            default:                    state_d = ST_IDLE;
        endcase
    end

    // state register and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN) cnt_q <= cnt_q + 1'b1;
            else                   cnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN:  begin step = 1'b1; busy = 1'b1; end
            ST_DONE: begin done = 1'b1; busy = 1'b1; end
            default: ;
        endcase
    end

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

    // R2
    load_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && !done));

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic [2*WIDTH-1:0] prod
);
    import booth_pkg::*;

    logic [2*WIDTH-1:0] prod_q;
    logic [WIDTH-1:0]   mcand_q;
    logic               prev_q;
    logic [WIDTH-1:0]   hi_half, lo_half;
    logic [WIDTH:0]     ext_hi, ext_m, sum;
    booth_op_t          op;

    assign hi_half = prod_q[2*WIDTH-1:WIDTH];
    assign lo_half = prod_q[WIDTH-1:0];
    assign ext_hi  = {hi_half[WIDTH-1], hi_half};
    assign ext_m   = {mcand_q[WIDTH-1], mcand_q};
    assign op      = booth_decode(lo_half[0], prev_q);

    // one extra bit keeps the sign right when the multiplicand is the most negative value
    always_comb begin
        unique case (op)
            OP_ADD:  sum = ext_hi + ext_m;
            OP_SUB:  sum = ext_hi - ext_m;
            default: sum = ext_hi;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q  <= '0;
            mcand_q <= '0;
            prev_q  <= 1'b0;
        end else if (load) begin
            prod_q  <= {{WIDTH{1'b0}}, mplier_in};
            mcand_q <= mcand_in;
            prev_q  <= 1'b0;
        end else if (step) begin
            prod_q  <= {sum, lo_half[WIDTH-1:1]};
            prev_q  <= lo_half[0];
        end
    end

    assign prod = prod_q;

    // R2
    load_clears_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (prod_q[2*WIDTH-1:WIDTH] == '0 && prod_q[WIDTH-1:0] == $past(mplier_in) && !prev_q));

    // R9
    noop_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && op == OP_NONE) |=> (prod_q[2*WIDTH-2:0] == $past(prod_q[2*WIDTH-1:1])
                                     && prod_q[2*WIDTH-1] == $past(prod_q[2*WIDTH-1])));

    // R7
    mcand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(mcand_q));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(prod_q));

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] prod_hi,
    output logic [WIDTH-1:0] prod_lo
);
    logic               load, step;
    logic [2*WIDTH-1:0] prod;

    booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    booth_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .mcand_in  (op_a),
        .mplier_in (op_b),
        .prod      (prod)
    );

    assign prod_hi = prod[2*WIDTH-1:WIDTH];
    assign prod_lo = prod[WIDTH-1:0];

    // R8
    done_result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable({prod_hi, prod_lo}));

endmodule

// File: tb/booth_seq_mul_test.sv
module booth_seq_mul_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        busy, done;
    logic [31:0] prod_hi, prod_lo;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    booth_seq_mul uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
    );

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        logic signed [63:0] ea, eb;
        ea = {{32{a[31]}}, a};
        eb = {{32{b[31]}}, b};
        return ea * eb;
    endfunction

    // Start an operation; optionally pulse start again during run (at step k) and during done.
    task automatic run_mul(input string req, input logic [31:0] a, input logic [31:0] b,
                           input bit poke);
        int n;
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(posedge clk);               // accepting edge
        @(negedge clk);
        start = 1'b0;
        check64({req, " R2 busy after accept"}, {63'd0, busy}, 64'd1);
        n = 0;
        for (int i = 1; i <= 40; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (poke && i == 5) begin
                op_a = 32'h1234_5678; op_b = 32'h7654_3210; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done) begin n = i; break; end
            check64({req, " R2 busy during run"}, {63'd0, busy}, 64'd1);
        end
        check64({req, " R3 done latency"}, 64'(n), 64'd32);
        check64({req, " product"}, {prod_hi, prod_lo}, ref_mul(a, b));
        if (poke) start = 1'b1;       // start asserted during the done cycle
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check64({req, " R3 done one cycle"}, {63'd0, done}, 64'd0);
        check64({req, " R8 hold after done"}, {prod_hi, prod_lo}, ref_mul(a, b));
        if (poke) check64({req, " R7 start ignored, idle after"}, {63'd0, busy}, 64'd0);
    endtask

    task automatic t_reset();
        check64("R1 reset state", {busy, done, 30'd0, prod_hi}, 64'd0);
        check64("R1 reset lo", {32'd0, prod_lo}, 64'd0);
    endtask

    task automatic t_positive();
        run_mul("R4 3x5", 32'd3, 32'd5, 1'b0);
        run_mul("R4 large", 32'h7FFF_FFFF, 32'h0001_2345, 1'b0);
    endtask

    task automatic t_signed();
        run_mul("R5 -2x7", 32'hFFFF_FFFE, 32'd7, 1'b0);
        run_mul("R5 7x-2", 32'd7, 32'hFFFF_FFFE, 1'b0);
        run_mul("R5 neg x neg", 32'hFFFF_FF9C, 32'hFFFF_FFF3, 1'b0);
    endtask

    task automatic t_extremes();
        run_mul("R6 min x min", 32'h8000_0000, 32'h8000_0000, 1'b0);
        run_mul("R6 min x -1", 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        run_mul("R6 min x max", 32'h8000_0000, 32'h7FFF_FFFF, 1'b0);
        run_mul("R6 zero", 32'd0, 32'hDEAD_BEEF, 1'b0);
    endtask

    task automatic t_patterns();
        run_mul("R9 alternating", 32'h0000_1357, 32'h5555_5555, 1'b0);
        run_mul("R9 all ones", 32'h0BAD_F00D, 32'hFFFF_FFFF, 1'b0);
        run_mul("R9 alt neg", 32'hCAFE_0001, 32'hAAAA_AAAA, 1'b0);
    endtask

    task automatic t_ignore();
        run_mul("R7 poke", 32'hFFFF_F000, 32'h0000_0ABC, 1'b1);
    endtask

    task automatic t_hold();
        logic [63:0] keep;
        keep = {prod_hi, prod_lo};
        repeat (5) @(negedge clk);
        op_a = 32'h1111_1111; op_b = 32'h2222_2222;
        repeat (3) @(negedge clk);
        check64("R8 idle hold", {prod_hi, prod_lo}, keep);
        check64("R8 idle not busy", {63'd0, busy}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_positive();
        t_signed();
        t_extremes();
        t_patterns();
        t_ignore();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule